// File: doc/BRIEF.md
# Quad wiper register bank controller

This block holds the register file behind a four-channel digitally controlled resistor. Each channel owns one live wiper register, which sets the tap position and is driven out on `wiper_pos`. Each channel also owns four stored preset registers. All twenty registers are 8 bits wide, giving 256 tap positions. A small host port reaches them with a byte address, a write strobe, a read strobe, write data and an acknowledge strobe.

A mode register at byte address 07h decides where later channel accesses at addresses 00h–03h land. They land either on the live wiper registers or on one row of preset registers. Writing the mode register with its enable bit set also loads the chosen preset row into all four live wipers in the same cycle, provided the acknowledge strobe is high during that write. The preset registers are ordinary flip-flops. No serial framing, analog array or programming delay is modelled.

Top module: `wiper_bank_ctrl`

## Requirements
- R1: After reset the mode register reads 00h, every live wiper register (and so `wiper_pos`) is 00h, and every preset register reads back 00h.
- R2: The mode register sits at address 07h. Bit 0 is the preset-access enable, bits 2:1 are the preset row, and bits 7:3 are discarded on write and always read as 0.
- R3: With the enable bit at 0, a write to channel address c (00h–03h) loads only that channel's live wiper. `wiper_pos[8c+7:8c]` shows the new value on the cycle after the write, and the other three channels keep their values.
- R4: With the enable bit at 1, a write to channel address c loads the preset register of channel c in the selected row, and no live wiper changes.
- R5: A read of channel address c returns the live wiper of channel c when the enable bit is 0. It returns the preset register of channel c in the selected row when the enable bit is 1.
- R6: A mode write with bit 0 set while `host_ack` is high copies preset row `wdata[2:1]` of every channel into that channel's live wiper at once. The copy is visible on `wiper_pos` the cycle after the write.
- R7: A mode write with bit 0 set while `host_ack` is low updates the mode register but leaves every live wiper unchanged.
- R8: A mode write with bit 0 clear changes no live wiper and no preset register. It only redirects later accesses.
- R9: Reads of addresses 04h–06h and 08h–FFh return 00h. Writes to them change no register.
- R10: `host_rvalid` is high exactly on the cycle after a cycle with `host_rd` high. `host_rdata` then carries the value selected by the mode register in force at the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Write strobe, one access per cycle |
| host_rd | input | 1 | Read strobe, one access per cycle |
| host_addr | input | 8 | Byte address of the access |
| host_wdata | input | 8 | Write data |
| host_ack | input | 1 | Acknowledge strobe, enables the preset-to-wiper copy on a mode write |
| host_rdata | output | 8 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after host_rd |
| wiper_pos | output | 32 | Live wiper positions, channel c at bits 8c+7:8c |

## Verification
Every result of this block is due exactly one clock edge after the strobe that causes it. This covers a wiper load, a preset-row copy, a mode update and read data with its valid flag. The bench drives each strobe on a falling edge and keeps it for one cycle. It compares wiper positions on the next falling edge, after the single register stage has updated. Expected read values are queued when the read strobe is driven. The monitor pops one entry on each falling edge where `host_rvalid` is high, so a late, early or extra valid shows up as a miscompare.

// File: rtl/wb_pkg.sv
package wb_pkg;
  parameter int unsigned WB_DATA_W      = 8;
  parameter int unsigned WB_ADDR_W      = 8;
  parameter int unsigned WB_NUM_CH      = 4;
  parameter int unsigned WB_NUM_ROWS    = 4;
  parameter int unsigned WB_STATUS_ADDR = 7;
  localparam int unsigned WB_ROW_W = $clog2(WB_NUM_ROWS);
  localparam int unsigned WB_CH_W  = $clog2(WB_NUM_CH);

  // Mode register contents: preset row and preset-access enable (bit 0).
  typedef struct packed {
    logic [WB_ROW_W-1:0] row;
    logic                nv_sel;
  } wb_mode_t;
endpackage

// File: rtl/wb_addr_dec.sv
module wb_addr_dec
  import wb_pkg::*;
#(
  parameter int unsigned ADDR_W      = WB_ADDR_W,
  parameter int unsigned NUM_CH      = WB_NUM_CH,
  parameter int unsigned STATUS_ADDR = WB_STATUS_ADDR,
  localparam int unsigned CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  output logic              is_ch,
  output logic              is_mode,
  output logic [CH_W-1:0]   ch_idx,
  output logic              mode_wr,
  output logic [NUM_CH-1:0] ch_wr
);
  always_comb begin
    is_ch   = (host_addr < ADDR_W'(NUM_CH));
    is_mode = (host_addr == ADDR_W'(STATUS_ADDR));
    ch_idx  = host_addr[CH_W-1:0];
    mode_wr = host_wr & is_mode;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_wr
    assign ch_wr[c] = host_wr & is_ch & (ch_idx == CH_W'(c));
  end
endmodule

// File: rtl/wb_mode_reg.sv
module wb_mode_reg
  import wb_pkg::*;
#(
  parameter int unsigned DATA_W = WB_DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_wr,
  input  logic                host_ack,
  input  logic [DATA_W-1:0]   wdata,
  output wb_mode_t            mode_q,
  output logic [DATA_W-1:0]   mode_word,
  output logic                bcast_en,
  output logic [WB_ROW_W-1:0] bcast_row
);
  wb_mode_t mode_nxt;

  always_comb begin
    mode_nxt.row    = wdata[WB_ROW_W:1];
    mode_nxt.nv_sel = wdata[0];
    bcast_en        = mode_wr & wdata[0] & host_ack;
    bcast_row       = wdata[WB_ROW_W:1];
    mode_word       = '0;
    mode_word[WB_ROW_W:0] = mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (mode_wr) begin
      mode_q <= mode_nxt;
    end
  end
endmodule

// File: rtl/wb_channel.sv
module wb_channel
  import wb_pkg::*;
#(
  parameter int unsigned DATA_W   = WB_DATA_W,
  parameter int unsigned NUM_ROWS = WB_NUM_ROWS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                nv_sel,
  input  logic [WB_ROW_W-1:0] row_sel,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                bcast_en,
  input  logic [WB_ROW_W-1:0] bcast_row,
  output logic [DATA_W-1:0]   wcr_o,
  output logic [DATA_W-1:0]   rd_word_o
);
  logic [DATA_W-1:0]   dr_q [NUM_ROWS];
  logic [NUM_ROWS-1:0] dr_we;
  logic [DATA_W-1:0]   wcr_q;
  logic [DATA_W-1:0]   wcr_nxt;
  logic                wcr_we;

  always_comb begin
    wcr_we  = bcast_en | (wr_en & ~nv_sel);
    wcr_nxt = bcast_en ? dr_q[bcast_row] : wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcr_q <= '0;
    end else if (wcr_we) begin
      wcr_q <= wcr_nxt;
    end
  end

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    assign dr_we[r] = wr_en & nv_sel & (row_sel == WB_ROW_W'(r));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dr_q[r] <= '0;
      end else if (dr_we[r]) begin
        dr_q[r] <= wdata;
      end
    end
  end

  assign wcr_o     = wcr_q;
  assign rd_word_o = nv_sel ? dr_q[row_sel] : wcr_q;
endmodule

// File: rtl/wb_read_port.sv
module wb_read_port
  import wb_pkg::*;
#(
  parameter int unsigned DATA_W = WB_DATA_W,
  parameter int unsigned NUM_CH = WB_NUM_CH,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_en,
  input  logic                     is_ch,
  input  logic                     is_mode,
  input  logic [CH_W-1:0]          ch_idx,
  input  logic [NUM_CH*DATA_W-1:0] ch_words,
  input  logic [DATA_W-1:0]        mode_word,
  output logic [DATA_W-1:0]        rdata,
  output logic                     rvalid
);
  logic [DATA_W-1:0] rdata_nxt;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  always_comb begin
    if (is_mode) begin
      rdata_nxt = mode_word;
    end else if (is_ch) begin
      rdata_nxt = ch_words[ch_idx*DATA_W +: DATA_W];
    end else begin
      rdata_nxt = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rdata_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;
endmodule

// File: rtl/wiper_bank_ctrl.sv
module wiper_bank_ctrl
  import wb_pkg::*;
#(
  parameter int unsigned DATA_W      = WB_DATA_W,
  parameter int unsigned ADDR_W      = WB_ADDR_W,
  parameter int unsigned NUM_CH      = WB_NUM_CH,
  parameter int unsigned STATUS_ADDR = WB_STATUS_ADDR
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     host_wr,
  input  logic                     host_rd,
  input  logic [ADDR_W-1:0]        host_addr,
  input  logic [DATA_W-1:0]        host_wdata,
  input  logic                     host_ack,
  output logic [DATA_W-1:0]        host_rdata,
  output logic                     host_rvalid,
  output logic [NUM_CH*DATA_W-1:0] wiper_pos
);
  localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic                     is_ch;
  logic                     is_mode;
  logic [CH_W-1:0]          ch_idx;
  logic                     mode_wr;
  logic [NUM_CH-1:0]        ch_wr;
  wb_mode_t                 mode_q;
  logic [DATA_W-1:0]        mode_word;
  logic                     bcast_en;
  logic [WB_ROW_W-1:0]      bcast_row;
  logic [NUM_CH*DATA_W-1:0] ch_words;

  wb_addr_dec #(
    .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .STATUS_ADDR(STATUS_ADDR)
  ) u_dec (
    .host_wr  (host_wr),
    .host_addr(host_addr),
    .is_ch    (is_ch),
    .is_mode  (is_mode),
    .ch_idx   (ch_idx),
    .mode_wr  (mode_wr),
    .ch_wr    (ch_wr)
  );

  wb_mode_reg #(.DATA_W(DATA_W)) u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_wr  (mode_wr),
    .host_ack (host_ack),
    .wdata    (host_wdata),
    .mode_q   (mode_q),
    .mode_word(mode_word),
    .bcast_en (bcast_en),
    .bcast_row(bcast_row)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    wb_channel #(.DATA_W(DATA_W), .NUM_ROWS(WB_NUM_ROWS)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (ch_wr[c]),
      .nv_sel   (mode_q.nv_sel),
      .row_sel  (mode_q.row),
      .wdata    (host_wdata),
      .bcast_en (bcast_en),
      .bcast_row(bcast_row),
      .wcr_o    (wiper_pos[c*DATA_W +: DATA_W]),
      .rd_word_o(ch_words[c*DATA_W +: DATA_W])
    );
  end

  wb_read_port #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (host_rd),
    .is_ch    (is_ch),
    .is_mode  (is_mode),
    .ch_idx   (ch_idx),
    .ch_words (ch_words),
    .mode_word(mode_word),
    .rdata    (host_rdata),
    .rvalid   (host_rvalid)
  );
endmodule

// File: rtl/wiper_bank_ctrl_chk.sv
module wiper_bank_ctrl_chk
  import wb_pkg::*;
#(
  parameter int unsigned DATA_W      = WB_DATA_W,
  parameter int unsigned ADDR_W      = WB_ADDR_W,
  parameter int unsigned NUM_CH      = WB_NUM_CH,
  parameter int unsigned STATUS_ADDR = WB_STATUS_ADDR
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     host_wr,
  input logic                     host_rd,
  input logic [ADDR_W-1:0]        host_addr,
  input logic [DATA_W-1:0]        host_wdata,
  input logic                     host_ack,
  input logic [DATA_W-1:0]        host_rdata,
  input logic                     host_rvalid,
  input logic [NUM_CH*DATA_W-1:0] wiper_pos
);
  logic at_mode;
  logic at_unused;
  assign at_mode   = (host_addr == ADDR_W'(STATUS_ADDR));
  assign at_unused = !at_mode && (host_addr >= ADDR_W'(NUM_CH));

  // R10
  rvalid_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> host_rvalid);

  // R10
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> !host_rvalid);

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && at_mode) |=> (host_rdata[DATA_W-1:WB_ROW_W+1] == '0));

  // R9
  unused_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && at_unused) |=> (host_rdata == '0));

  // R9
  unused_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && at_unused) |=> $stable(wiper_pos));

  // R8
  mode_clear_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && at_mode && !host_wdata[0]) |=> $stable(wiper_pos));

  // R7
  no_ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && at_mode && !host_ack) |=> $stable(wiper_pos));

  // R3
  wiper_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_wr |=> $stable(wiper_pos));
endmodule

bind wiper_bank_ctrl wiper_bank_ctrl_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .STATUS_ADDR(STATUS_ADDR)
) u_chk (.*);

// File: tb/wiper_bank_ctrl_tb.sv
`timescale 1ns/1ps
module wiper_bank_ctrl_tb;
  logic        clk;
  logic        rst_n;
  logic        host_wr;
  logic        host_rd;
  logic [7:0]  host_addr;
  logic [7:0]  host_wdata;
  logic        host_ack;
  logic [7:0]  host_rdata;
  logic        host_rvalid;
  logic [31:0] wiper_pos;

  wiper_bank_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid), .wiper_pos(wiper_pos)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int unsigned n_vec;
  int unsigned n_bad;
  bit          done;

  logic [7:0] m_wcr [4];
  logic [7:0] m_dr  [4][4];
  logic [1:0] m_row;
  logic       m_nv;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic chk_wipers(string tag);
    for (int c = 0; c < 4; c++) begin
      check(tag, wiper_pos[c*8 +: 8], m_wcr[c]);
    end
  endtask

  task automatic wr_op(logic [7:0] a, logic [7:0] d, logic ack);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d; host_ack = ack;
    if (a == 8'h07) begin
      m_row = d[2:1];
      m_nv  = d[0];
      if (d[0] && ack) begin
        for (int c = 0; c < 4; c++) m_wcr[c] = m_dr[c][d[2:1]];
      end
    end else if (a < 8'h04) begin
      if (m_nv) m_dr[a[1:0]][m_row] = d;
      else      m_wcr[a[1:0]]       = d;
    end
    @(negedge clk);
    host_wr = 1'b0; host_ack = 1'b0;
  endtask

  task automatic rd_op(logic [7:0] a, string tag);
    logic [7:0] e;
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    if (a == 8'h07)     e = {5'b0, m_row, m_nv};
    else if (a < 8'h04) e = m_nv ? m_dr[a[1:0]][m_row] : m_wcr[a[1:0]];
    else                e = 8'h00;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  // Monitor: pops one expected read per valid cycle.
  always @(negedge clk) begin
    if (rst_n && host_rvalid) begin
      if (exp_q.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL R10 unexpected valid actual=1 expected=0");
      end else begin
        check(tag_q.pop_front(), host_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    n_vec = 0; n_bad = 0; done = 1'b0;
    host_wr = 0; host_rd = 0; host_addr = 0; host_wdata = 0; host_ack = 0;
    rst_n = 1'b0;
    m_row = 0; m_nv = 0;
    for (int c = 0; c < 4; c++) begin
      m_wcr[c] = 0;
      for (int r = 0; r < 4; r++) m_dr[c][r] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_wipers("R1 reset wipers");
    rd_op(8'h07, "R1 reset mode");
    for (int c = 0; c < 4; c++) rd_op(8'(c), "R1 reset wiper read");
    wr_op(8'h07, 8'h07, 1'b0);
    rd_op(8'h00, "R1 reset preset read");
    wr_op(8'h07, 8'h00, 1'b0);

    // R3 single wiper write, R5 live read
    wr_op(8'h01, 8'h5A, 1'b0);
    chk_wipers("R3 single wiper write");
    rd_op(8'h01, "R5 live read");

    // R6 broadcast of an all-zero row
    wr_op(8'h07, 8'h03, 1'b1);
    chk_wipers("R6 broadcast row1");

    // R4 preset writes leave wipers alone
    wr_op(8'h00, 8'h11, 1'b0);
    wr_op(8'h01, 8'h22, 1'b0);
    wr_op(8'h02, 8'h33, 1'b0);
    wr_op(8'h03, 8'h44, 1'b0);
    chk_wipers("R4 preset write wipers unchanged");
    rd_op(8'h02, "R5 preset read");

    wr_op(8'h07, 8'h05, 1'b1);
    chk_wipers("R6 broadcast row2");
    for (int c = 0; c < 4; c++) wr_op(8'(c), 8'hA0 + 8'(c), 1'b0);
    rd_op(8'h03, "R4 preset row2 read");

    // R7 no ack, no copy
    wr_op(8'h07, 8'h03, 1'b0);
    chk_wipers("R7 no ack copy");
    rd_op(8'h07, "R7 mode updated");
    wr_op(8'h07, 8'h03, 1'b1);
    chk_wipers("R6 broadcast row1 values");

    // R2 reserved bits dropped
    wr_op(8'h07, 8'hFD, 1'b1);
    rd_op(8'h07, "R2 reserved bits");
    chk_wipers("R6 broadcast row2 values");

    // R8 clear enable: no change, then preset content intact
    wr_op(8'h07, 8'h00, 1'b1);
    chk_wipers("R8 clear enable wipers");
    rd_op(8'h00, "R8 live read");
    wr_op(8'h07, 8'h02, 1'b1);
    chk_wipers("R8 row set without enable");
    rd_op(8'h03, "R8 live read ch3");
    wr_op(8'h03, 8'h77, 1'b0);
    chk_wipers("R3 ch3 write");
    wr_op(8'h07, 8'h03, 1'b0);
    rd_op(8'h00, "R8 preset row1 intact");

    // R9 unused addresses
    wr_op(8'h07, 8'h00, 1'b0);
    wr_op(8'h05, 8'hFF, 1'b1);
    wr_op(8'h80, 8'hFF, 1'b1);
    chk_wipers("R9 unused writes");
    rd_op(8'h05, "R9 unused read 05");
    rd_op(8'h80, "R9 unused read 80");
    rd_op(8'h07, "R9 mode untouched");

    // R10 read reflects mode in force at read time
    wr_op(8'h07, 8'h01, 1'b0);
    rd_op(8'h00, "R10 read after mode change");
    wr_op(8'h07, 8'h00, 1'b0);
    rd_op(8'h00, "R10 read live after mode change");

    repeat (3) @(negedge clk);
    check("R10 idle valid", {7'b0, host_rvalid}, 8'h00);
    check("R10 queue drained", 8'(exp_q.size()), 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule